// File: doc/BRIEF.md
# Packed Decimal Edit Engine

This block turns a packed decimal number into printable text by walking a pattern held in an internal byte buffer. The host first writes the pattern into the buffer one byte at a time. It then presents the packed source value, its length in bytes, the pattern length and a mark-mode select, and pulses `start`. The engine handles one pattern byte per clock, from left to right. Digit-select bytes take source digits in order. A significance flag decides whether leading zeros and punctuation become the fill character. Each edited byte is written back over the pattern byte it replaces.

When the run ends, `done` is held high and the host reads the edited text through a read port. Next to the text the engine gives a two-bit condition code, a flag for a bad sign code, and a flag for a bad digit code that stops the run early. In mark mode it also gives the position of the first digit that started significance on its own.

Top module: `pdec_edit_engine`

## Requirements
- R1: Pattern byte 0 is the fill character and is written back unchanged. Significance is off when a run starts. Exactly one pattern byte is handled per clock, so `done` rises `pat_len` clocks after the edge that accepts `start`, unless R8 ends the run early.
- R2: Byte 0x20 takes the next source digit d. If d is zero and significance is off, it writes the fill character. Otherwise it writes 0xF0+d. A nonzero d turns significance on.
- R3: Byte 0x21 acts as 0x20 and also turns significance on for the positions after it. A zero digit at this position is still written as fill.
- R4: Byte 0x22 is replaced by the fill character and turns significance off.
- R5: Any other byte at position 1 or higher is kept while significance is on. It is replaced by the fill character while significance is off.
- R6: Source byte 0 sits in `src_data[127:120]`, and each byte gives its high nibble before its low nibble. A source of L bytes holds 2L-1 digits, and its last low nibble is the sign. Right after the final digit is taken, significance is set to 0 for sign 0xC or 0xF and to 1 for sign 0xD.
- R7: Any sign nibble other than 0xC, 0xD or 0xF sets `sign_err` and is handled as positive.
- R8: A digit nibble above 9 sets `data_err` and ends the run, with `done` asserted on that same edge. That pattern byte and all bytes after it stay unchanged.
- R9: When `done` is high, `cc` is 0 if every digit taken was zero, 1 if the value is nonzero and the sign was 0xD, and 2 if the value is nonzero and positive.
- R10: In mark mode, `mark_valid` and `mark_pos` give the index of the first pattern byte where a nonzero digit turned significance on. Significance forced on by 0x21 does not count. With mark mode off, `mark_valid` stays 0.
- R11: Once all 2L-1 digits have been taken, bytes 0x20 and 0x21 are handled as in R5.
- R12: While `busy` is high, pattern writes and `start` pulses are ignored.
- R13: After reset, `busy`, `done`, `cc`, `sign_err`, `data_err` and `mark_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Pattern byte write strobe (used only when idle) |
| ld_addr | input | 8 | Pattern byte index to write |
| ld_data | input | 8 | Pattern byte value |
| pat_len | input | 9 | Pattern length in bytes, 1 to 256, sampled at start |
| src_data | input | 128 | Packed source, byte 0 in the top bits, sampled at start |
| src_len | input | 5 | Source length in bytes, 1 to 16, sampled at start |
| mark_mode | input | 1 | Enables first-significant-digit reporting, sampled at start |
| start | input | 1 | Starts a run when idle |
| rd_addr | input | 8 | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_addr` (combinational) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| cc | output | 2 | Condition code |
| sign_err | output | 1 | Bad sign nibble seen |
| data_err | output | 1 | Bad digit nibble seen, run ended early |
| mark_valid | output | 1 | `mark_pos` holds a recorded position |
| mark_pos | output | 8 | Index of the first significant digit |

## Verification
The clocked properties check on every cycle that the pattern index moves one step per clock while busy, that `busy` and `done` never overlap, and that a bad digit ends the run at once. They also check that the digit pointer never passes the sign nibble and that a recorded mark stays fixed and exists only in mark mode. What each byte actually turns into can only be shown by the bench's scenarios. That covers fill against digit against kept punctuation, significance forced by 0x21 against significance started by a digit, a separator clearing significance, the sign turning significance back on for trailing text, and the condition code for zero, negative and positive values.

// File: rtl/pdedit_pkg.sv
package pdedit_pkg;

    localparam logic [7:0] PB_DIGIT     = 8'h20;
    localparam logic [7:0] PB_DIGIT_SIG = 8'h21;
    localparam logic [7:0] PB_FIELD     = 8'h22;
    localparam logic [3:0] ZONE_NIB     = 4'hF;

    localparam logic [3:0] SGN_PLUS_A = 4'hC;
    localparam logic [3:0] SGN_MINUS  = 4'hD;
    localparam logic [3:0] SGN_PLUS_B = 4'hF;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_NEG  = 2'd1;
    localparam logic [1:0] CC_POS  = 2'd2;

    function automatic logic sign_negative(input logic [3:0] n);
        return n == SGN_MINUS;
    endfunction

    function automatic logic sign_known(input logic [3:0] n);
        return (n == SGN_PLUS_A) || (n == SGN_MINUS) || (n == SGN_PLUS_B);
    endfunction

endpackage

// File: rtl/edit_buf.sv
module edit_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/edit_nib_sel.sv
module edit_nib_sel #(
    parameter int NIBS = 32,
    parameter int IW   = $clog2(NIBS)
) (
    input  logic [4*NIBS-1:0] src,
    input  logic [IW:0]       idx,
    output logic [3:0]        nib
);

    logic [3:0] nibs [NIBS];

    // nibble 0 is the top nibble of the vector
    for (genvar g = 0; g < NIBS; g++) begin : g_split
        assign nibs[g] = src[4*NIBS-1-4*g -: 4];
    end

    assign nib = (idx < (IW+1)'(NIBS)) ? nibs[idx[IW-1:0]] : 4'h0;

endmodule

// File: rtl/edit_step.sv
module edit_step
    import pdedit_pkg::*;
(
    input  logic       first,
    input  logic [7:0] pat_byte,
    input  logic [7:0] fill,
    input  logic       sig,
    input  logic       have_digit,
    input  logic [3:0] digit,
    input  logic       last_digit,
    input  logic [3:0] sign_nib,
    output logic [7:0] out_byte,
    output logic       sig_next,
    output logic       take_digit,
    output logic       dig_bad,
    output logic       sig_from_digit,
    output logic       digit_nz,
    output logic       sign_seen,
    output logic       sign_neg,
    output logic       sign_bad
);

    logic is_sel;

    always_comb begin
        is_sel         = ((pat_byte == PB_DIGIT) || (pat_byte == PB_DIGIT_SIG)) && have_digit;
        out_byte       = pat_byte;
        sig_next       = sig;
        take_digit     = 1'b0;
        dig_bad        = 1'b0;
        sig_from_digit = 1'b0;
        digit_nz       = 1'b0;
        sign_seen      = 1'b0;
        sign_neg       = 1'b0;
        sign_bad       = 1'b0;

        if (first) begin
            out_byte = pat_byte;
        end else if (is_sel) begin
            take_digit = 1'b1;
            if (digit > 4'd9) begin
                dig_bad  = 1'b1;
                out_byte = pat_byte;
            end else begin
                digit_nz       = (digit != 4'd0);
                sig_from_digit = digit_nz && !sig;
                out_byte       = (!digit_nz && !sig) ? fill : {ZONE_NIB, digit};
                sig_next       = sig || digit_nz || (pat_byte == PB_DIGIT_SIG);
                if (last_digit) begin
                    sign_seen = 1'b1;
                    sign_neg  = sign_negative(sign_nib);
                    sign_bad  = !sign_known(sign_nib);
                    sig_next  = sign_neg;
                end
            end
        end else if (pat_byte == PB_FIELD) begin
            out_byte = fill;
            sig_next = 1'b0;
        end else begin
            out_byte = sig ? pat_byte : fill;
        end
    end

endmodule

// File: rtl/pdec_edit_engine.sv
module pdec_edit_engine
    import pdedit_pkg::*;
#(
    parameter  int PAT_BYTES = 256,
    parameter  int SRC_BYTES = 16,
    localparam int AW        = $clog2(PAT_BYTES),
    localparam int LW        = AW + 1,
    localparam int SRC_W     = 8 * SRC_BYTES,
    localparam int SLW       = $clog2(SRC_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [AW-1:0]    ld_addr,
    input  logic [7:0]       ld_data,
    input  logic [LW-1:0]    pat_len,
    input  logic [SRC_W-1:0] src_data,
    input  logic [SLW-1:0]   src_len,
    input  logic             mark_mode,
    input  logic             start,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             done,
    output logic [1:0]       cc,
    output logic             sign_err,
    output logic             data_err,
    output logic             mark_valid,
    output logic [AW-1:0]    mark_pos
);

    localparam int NIBS = 2 * SRC_BYTES;
    localparam int NW   = SLW + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [AW-1:0]    idx;
        logic [LW-1:0]    plen;
        logic [NW-1:0]    nib;
        logic [NW-1:0]    ndig;
        logic [SRC_W-1:0] src;
        logic [7:0]       fill;
        logic             sig;
        logic             nonzero;
        logic             neg;
        logic             sign_err;
        logic             data_err;
        logic             mark_en;
        logic             mark_valid;
        logic [AW-1:0]    mark_pos;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [7:0]  eng_byte;
    logic [3:0]  cur_nib, sign_nib;
    logic        first_pos, have_digit, last_digit, last_pos;
    logic [7:0]  fill_cur;
    logic [7:0]  step_byte;
    logic        sig_next, take_digit, dig_bad, sig_from_digit, digit_nz;
    logic        sign_seen, sign_neg, sign_bad;
    logic        buf_we;
    logic [AW-1:0] buf_waddr;
    logic [7:0]  buf_wdata;
    logic [LW-1:0] plen_start;
    logic [SLW-1:0] slen_start;

    edit_buf #(.DEPTH(PAT_BYTES), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (st_q.idx),
        .rdata_a (eng_byte),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    edit_nib_sel #(.NIBS(NIBS)) u_dig_sel (
        .src (st_q.src),
        .idx (st_q.nib),
        .nib (cur_nib)
    );

    edit_nib_sel #(.NIBS(NIBS)) u_sgn_sel (
        .src (st_q.src),
        .idx (st_q.ndig),
        .nib (sign_nib)
    );

    assign first_pos  = (st_q.idx == '0);
    assign have_digit = (st_q.nib < st_q.ndig);
    assign last_digit = (st_q.nib == st_q.ndig - NW'(1));
    assign last_pos   = ({1'b0, st_q.idx} == st_q.plen - LW'(1));
    assign fill_cur   = first_pos ? eng_byte : st_q.fill;

    edit_step u_step (
        .first          (first_pos),
        .pat_byte       (eng_byte),
        .fill           (fill_cur),
        .sig            (st_q.sig),
        .have_digit     (have_digit),
        .digit          (cur_nib),
        .last_digit     (last_digit),
        .sign_nib       (sign_nib),
        .out_byte       (step_byte),
        .sig_next       (sig_next),
        .take_digit     (take_digit),
        .dig_bad        (dig_bad),
        .sig_from_digit (sig_from_digit),
        .digit_nz       (digit_nz),
        .sign_seen      (sign_seen),
        .sign_neg       (sign_neg),
        .sign_bad       (sign_bad)
    );

    // buffer write port: host while idle, engine while running
    always_comb begin
        if (st_q.busy) begin
            buf_we    = !dig_bad;
            buf_waddr = st_q.idx;
            buf_wdata = step_byte;
        end else begin
            buf_we    = ld_we;
            buf_waddr = ld_addr;
            buf_wdata = ld_data;
        end
    end

    assign plen_start = (pat_len == '0) ? LW'(1) : pat_len;
    assign slen_start = (src_len == '0) ? SLW'(1) : src_len;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy       = 1'b1;
                st_d.done       = 1'b0;
                st_d.idx        = '0;
                st_d.plen       = plen_start;
                st_d.nib        = '0;
                st_d.ndig       = {slen_start, 1'b0} - NW'(1);
                st_d.src        = src_data;
                st_d.fill       = 8'h00;
                st_d.sig        = 1'b0;
                st_d.nonzero    = 1'b0;
                st_d.neg        = 1'b0;
                st_d.sign_err   = 1'b0;
                st_d.data_err   = 1'b0;
                st_d.mark_en    = mark_mode;
                st_d.mark_valid = 1'b0;
                st_d.mark_pos   = '0;
            end
        end else begin
            if (first_pos) begin
                st_d.fill = eng_byte;
            end
            if (dig_bad) begin
                st_d.data_err = 1'b1;
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
            end else begin
                st_d.sig = sig_next;
                if (take_digit) begin
                    st_d.nib = st_q.nib + NW'(1);
                end
                if (digit_nz) begin
                    st_d.nonzero = 1'b1;
                end
                if (sign_seen) begin
                    st_d.neg      = sign_neg;
                    st_d.sign_err = sign_bad;
                end
                if (st_q.mark_en && !st_q.mark_valid && sig_from_digit) begin
                    st_d.mark_valid = 1'b1;
                    st_d.mark_pos   = st_q.idx;
                end
                if (last_pos) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + AW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign sign_err   = st_q.sign_err;
    assign data_err   = st_q.data_err;
    assign mark_valid = st_q.mark_valid;
    assign mark_pos   = st_q.mark_pos;
    assign cc         = !st_q.nonzero ? CC_ZERO : (st_q.neg ? CC_NEG : CC_POS);

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R1

    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !st_q.sig && st_q.idx == '0)); // R1

    AST_ONE_BYTE_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_pos && !dig_bad) |=> (busy && st_q.idx == $past(st_q.idx) + AW'(1))); // R1

    AST_BAD_DIGIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_err) |-> (done && !busy)); // R8

    AST_NIB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.nib <= st_q.ndig)); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(cc))); // R9

    AST_MARK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_valid && !(start && !busy)) |=> (mark_valid && $stable(mark_pos))); // R10

    AST_MARK_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_valid |-> st_q.mark_en); // R10

endmodule

// File: tb/pdec_edit_engine_tb.sv
module pdec_edit_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_we = 1'b0;
    logic [7:0]   ld_addr = '0;
    logic [7:0]   ld_data = '0;
    logic [8:0]   pat_len = '0;
    logic [127:0] src_data = '0;
    logic [4:0]   src_len = '0;
    logic         mark_mode = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic         busy, done, sign_err, data_err, mark_valid;
    logic [1:0]   cc;
    logic [7:0]   mark_pos;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdec_edit_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .pat_len(pat_len), .src_data(src_data), .src_len(src_len), .mark_mode(mark_mode),
        .start(start), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .cc(cc), .sign_err(sign_err), .data_err(data_err), .mark_valid(mark_valid),
        .mark_pos(mark_pos)
    );

    // pattern, source and expected text are left aligned (byte 0 at the top)
    localparam logic [79:0] T_PAT [NV] = '{
        80'h40202020_21204B20_2000, 80'h40202120_4B202060_0000,
        80'h5C202020_C3D90000_0000, 80'h5C202020_C3D90000_0000,
        80'h40212022_20202000_0000, 80'h40202020_20000000_0000,
        80'h40204B00_00000000_0000, 80'h40202020_00000000_0000,
        80'h40000000_00000000_0000 };
    localparam logic [79:0] T_EXP [NV] = '{
        80'h40404040_F1F24BF3_F400, 80'h404040F0_4BF0F060_0000,
        80'h5CF1F2F3_C3D90000_0000, 80'h5CF1F2F3_5C5C0000_0000,
        80'h4040F040_40F5F000_0000, 80'h40F72020_20000000_0000,
        80'h40F34000_00000000_0000, 80'h40F12020_00000000_0000,
        80'h40000000_00000000_0000 };
    localparam logic [31:0] T_SRC [NV] = '{
        32'h0001234C, 32'h00000D00, 32'h123D0000, 32'h123C0000, 32'h00050F00,
        32'h7D000000, 32'h3A000000, 32'h1B2C0000, 32'h5C000000 };
    localparam int T_PLEN [NV] = '{9, 8, 6, 6, 7, 5, 3, 4, 1};
    localparam int T_SLEN [NV] = '{4, 3, 2, 2, 3, 1, 1, 2, 1};
    localparam int T_CYC  [NV] = '{9, 8, 6, 6, 7, 5, 3, 3, 1};
    localparam logic [NV-1:0] T_MARK = 9'b1_0011_0011; // bit v = mark mode of row v
    localparam logic [NV-1:0] T_MV   = 9'b0_0011_0001;
    localparam int T_MP  [NV] = '{4, 0, 0, 0, 5, 1, 0, 0, 0};
    localparam int T_CC  [NV] = '{2, 0, 1, 2, 2, 1, 2, 2, 0};
    localparam logic [NV-1:0] T_SE = 9'b0_0100_0000;
    localparam logic [NV-1:0] T_DE = 9'b0_1000_0000;

    function automatic string byte_tag(input int v);
        case (v)
            0: return "R2";   // zero suppression, digit start, punctuation kept
            1: return "R3";   // significance forced by 0x21
            2: return "R6";   // minus sign keeps trailing text
            3: return "R5";   // plus sign suppresses trailing text
            4: return "R4";   // separator clears significance
            5: return "R11";  // digit selects after digits run out
            6: return "R7";   // bad sign handled as plus
            7: return "R8";   // bad digit leaves the rest untouched
            default: return "R1"; // fill byte only
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_pat(input logic [79:0] pat, input int plen);
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = 8'(i);
            ld_data = pat[79-8*i -: 8];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R13: state after reset
        chk("R13 busy", 32'(busy), 0);
        chk("R13 done", 32'(done), 0);
        chk("R13 cc", 32'(cc), 0);
        chk("R13 flags", {29'd0, sign_err, data_err, mark_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            load_pat(T_PAT[v], T_PLEN[v]);
            src_data  = {T_SRC[v], 96'h0};
            src_len   = 5'(T_SLEN[v]);
            pat_len   = 9'(T_PLEN[v]);
            mark_mode = T_MARK[v];
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(cyc);
            chk("R1 cycles", 32'(cyc), 32'(T_CYC[v]));
            for (int i = 0; i < T_PLEN[v]; i++) begin
                rd_addr = 8'(i);
                #1;
                chk(byte_tag(v), 32'(rd_data), 32'(T_EXP[v][79-8*i -: 8]));
            end
            chk("R9 cc", 32'(cc), 32'(T_CC[v]));
            chk("R7 sign_err", 32'(sign_err), 32'(T_SE[v]));
            chk("R8 data_err", 32'(data_err), 32'(T_DE[v]));
            chk("R10 mark_valid", 32'(mark_valid), 32'(T_MV[v]));
            if (T_MV[v]) chk("R10 mark_pos", 32'(mark_pos), 32'(T_MP[v]));
        end

        // R12: load and start during a run have no effect
        load_pat(T_PAT[2], 6);
        src_data = {32'h123D0000, 96'h0};
        src_len  = 5'd2;
        pat_len  = 9'd6;
        mark_mode = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        @(negedge clk);
        ld_we    = 1'b1;
        ld_addr  = 8'd5;
        ld_data  = 8'hAA;
        start    = 1'b1;
        pat_len  = 9'd2;
        @(negedge clk);
        ld_we    = 1'b0;
        start    = 1'b0;
        wait_done(cyc);
        chk("R12 cycles", 32'(cyc + 2), 6);
        rd_addr = 8'd5;
        #1;
        chk("R12 byte5", 32'(rd_data), 32'hD9);
        chk("R12 cc", 32'(cc), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule